// File: doc/BRIEF.md
# Transmit Jabber and Idle Controller

This block drives the enable of a twisted-pair line driver on the transmit side of a 10 Mb/s port. All of its timing runs from a single 10 MHz clock. Transmission starts on a qualified data edge, which is an edge seen while transmit-enable is high. The driver then stays on until a short hold timer runs out with no further edge. While the line is quiet, the block asks for a single positive link beat at a fixed interval.

Two supervisory functions sit on top of this path. A long-run watchdog catches a transmitter that never stops. It cuts the driver off, and it releases the driver only after a long stretch with no qualified edges. A post-frame self-test raises the collision/status flag for a short window after each normal end of frame, so that the collision reporting path can be tested. The block also decides when the transmit-to-receive loopback path may be open. It hands the collision input on to the status flag unless full-duplex operation is selected.

Every count limit is a parameter, so a test can use short windows.

Top module: `txJabberIdleCtl`

## Requirements
- R1: While reset is asserted, driverEn, jabberFlag, linkPulseReq, colStatusFlag and loopbackEn are all low.
- R2: A qualified edge (txEnable high and txData different from its value at the previous clock) seen in the idle state turns driverEn on at the next cycle. Edges while txEnable is low have no effect.
- R3: driverEn stays high for HOLD_CYCLES cycles after the last qualified edge, and every new qualified edge restarts that count. driverEn falls when the count expires, or at the first cycle that samples txEnable low.
- R4: When driverEn has been high for JABBER_CYCLES consecutive cycles, the block enters jabber. In jabber, driverEn and loopbackEn are low and both jabberFlag and colStatusFlag are high.
- R5: Jabber ends only after RECOVER_CYCLES consecutive cycles with no qualified edge. Any qualified edge restarts that count.
- R6: In the idle state, linkPulseReq is high for the last BEAT_WIDTH cycles of every BEAT_PERIOD-cycle period. Periods are counted from entry into idle, and the signal is never high while driving or in jabber.
- R7: When driving ends by R3 with sqeTestEn high at that cycle, colStatusFlag is high for SQE_CYCLES cycles, starting the cycle after driverEn falls.
- R8: colStatusFlag follows collisionIn when fullDuplex is low. When fullDuplex is high, collisionIn is ignored, but the R7 window still appears.
- R9: loopbackEn is high exactly when driverEn is high, fullDuplex is low and collisionIn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz timing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmit enable from the controller |
| txData | input | 1 | Serial transmit data stream |
| collisionIn | input | 1 | Collision indication from the receive side |
| fullDuplex | input | 1 | High selects full-duplex operation |
| sqeTestEn | input | 1 | High enables the post-frame status test |
| driverEn | output | 1 | Line driver enable |
| linkPulseReq | output | 1 | Request for a positive link beat |
| jabberFlag | output | 1 | Jabber state indication |
| colStatusFlag | output | 1 | Collision, jabber or test status |
| loopbackEn | output | 1 | Internal loopback path enable |

## Verification
Directed cases come first:
- Toggling data with enable low shows that unqualified edges are ignored.
- A short frame separates the hold-timer release from an enable-low release, and it places the status test window.
- A continuous toggle stream separates the jabber onset from a frame that is merely long.
- Continued toggling inside jabber, followed by silence, shows that only a quiet period clears the state. It also fixes the phase of the first link beat after recovery.

Random phases then mix the following, with collision pulses and full-duplex and test-enable changes:
- quiet holds
- gappy frames
- unbroken streams
- enable-low noise

These phases are compared each cycle with a reference model. Together they expose:
- hold and restart counting errors
- beat wrap errors
- collision gating errors

// File: rtl/txj_pkg.sv
package txj_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_JAB  = 2'd2
  } txState_e;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic idleRestart;  // qualified edge: restart the hold timer
    logic sendRun;      // driving the line
    logic jabRun;       // jabber lockout
    logic idleRun;      // quiet line, beats allowed
    logic sqeLoad;      // start the post-frame test window
  } ctlStrobe_t;

  // conditions reported by the datapath to the control
  typedef struct packed {
    logic txAct;        // qualified data edge this cycle
    logic holdDone;     // hold timer at its last count
    logic longDone;     // run-length watchdog at its last count
    logic quietDone;    // recovery timer at its last count
  } dpStatus_t;

endpackage

// File: rtl/txjCounter.sv
module txjCounter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = ($clog2(LIMIT) > 0) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txjControl.sv
module txjControl
  import txj_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       sqeTestEn,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);
  txState_e state, stateNext;
  logic restartNow, sqeNow;

  always_comb begin
    stateNext  = state;
    restartNow = 1'b0;
    sqeNow     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.txAct) begin
          stateNext  = ST_SEND;
          restartNow = 1'b1;
        end
      end
      ST_SEND: begin
        if (status.longDone) begin
          stateNext = ST_JAB;
        end else if (status.txAct) begin
          restartNow = 1'b1;
        end else if (!txEnable || status.holdDone) begin
          stateNext = ST_IDLE;
          sqeNow    = sqeTestEn;
        end
      end
      ST_JAB: begin
        if (status.quietDone && !status.txAct) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.idleRestart = restartNow;
  assign strobe.sendRun     = (state == ST_SEND);
  assign strobe.jabRun      = (state == ST_JAB);
  assign strobe.idleRun     = (state == ST_IDLE);
  assign strobe.sqeLoad     = sqeNow;
endmodule

// File: rtl/txjDatapath.sv
module txjDatapath
  import txj_pkg::*;
#(
  parameter int HOLD_CYCLES    = 3,
  parameter int JABBER_CYCLES  = 200000,
  parameter int RECOVER_CYCLES = 5000000,
  parameter int BEAT_PERIOD    = 160000,
  parameter int BEAT_WIDTH     = 1,
  parameter int SQE_CYCLES     = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       txData,
  input  logic       collisionIn,
  input  logic       fullDuplex,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output logic       driverEn,
  output logic       jabberFlag,
  output logic       linkPulseReq,
  output logic       colStatusFlag,
  output logic       loopbackEn
);
  localparam int BCW = ($clog2(BEAT_PERIOD) > 0) ? $clog2(BEAT_PERIOD) : 1;
  localparam int SCW = $clog2(SQE_CYCLES + 1);
  localparam logic [BCW-1:0] BEAT_LAST = BCW'(BEAT_PERIOD - 1);
  localparam logic [BCW-1:0] BEAT_ON   = BCW'(BEAT_PERIOD - BEAT_WIDTH);
  localparam logic [SCW-1:0] SQE_LEN   = SCW'(SQE_CYCLES);

  logic           dataPrev;
  logic           txAct;
  logic [BCW-1:0] beatCnt;
  logic [SCW-1:0] sqeCnt;

  // previous data sample, tracks even during reset
  always_ff @(posedge clk) dataPrev <= txData;

  assign txAct = txEnable && (txData != dataPrev);

  txjCounter #(.LIMIT(HOLD_CYCLES)) holdTimer (
    .clk(clk), .rstN(rstN),
    .clr(strobe.idleRestart || !strobe.sendRun),
    .run(strobe.sendRun),
    .done(status.holdDone)
  );

  txjCounter #(.LIMIT(JABBER_CYCLES)) runWatch (
    .clk(clk), .rstN(rstN),
    .clr(!strobe.sendRun),
    .run(strobe.sendRun),
    .done(status.longDone)
  );

  txjCounter #(.LIMIT(RECOVER_CYCLES)) quietTimer (
    .clk(clk), .rstN(rstN),
    .clr(!strobe.jabRun || txAct),
    .run(strobe.jabRun),
    .done(status.quietDone)
  );

  assign status.txAct = txAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   beatCnt <= '0;
    else if (!strobe.idleRun)    beatCnt <= '0;
    else if (beatCnt == BEAT_LAST) beatCnt <= '0;
    else                         beatCnt <= beatCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sqeCnt <= '0;
    else if (strobe.sqeLoad) sqeCnt <= SQE_LEN;
    else if (sqeCnt != '0)  sqeCnt <= sqeCnt - 1'b1;
  end

  assign driverEn      = strobe.sendRun;
  assign jabberFlag    = strobe.jabRun;
  assign linkPulseReq  = strobe.idleRun && (beatCnt >= BEAT_ON);
  assign colStatusFlag = strobe.jabRun || (sqeCnt != '0) || (collisionIn && !fullDuplex);
  assign loopbackEn    = strobe.sendRun && !fullDuplex && !collisionIn;
endmodule

// File: rtl/txJabberIdleCtl.sv
module txJabberIdleCtl
  import txj_pkg::*;
#(
  parameter int HOLD_CYCLES    = 3,
  parameter int JABBER_CYCLES  = 200000,
  parameter int RECOVER_CYCLES = 5000000,
  parameter int BEAT_PERIOD    = 160000,
  parameter int BEAT_WIDTH     = 1,
  parameter int SQE_CYCLES     = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEnable,
  input  logic txData,
  input  logic collisionIn,
  input  logic fullDuplex,
  input  logic sqeTestEn,
  output logic driverEn,
  output logic linkPulseReq,
  output logic jabberFlag,
  output logic colStatusFlag,
  output logic loopbackEn
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  txjControl ctrl (
    .clk(clk), .rstN(rstN),
    .txEnable(txEnable), .sqeTestEn(sqeTestEn),
    .status(status), .strobe(strobe)
  );

  txjDatapath #(
    .HOLD_CYCLES(HOLD_CYCLES), .JABBER_CYCLES(JABBER_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES), .BEAT_PERIOD(BEAT_PERIOD),
    .BEAT_WIDTH(BEAT_WIDTH), .SQE_CYCLES(SQE_CYCLES)
  ) dpath (
    .clk(clk), .rstN(rstN),
    .txEnable(txEnable), .txData(txData),
    .collisionIn(collisionIn), .fullDuplex(fullDuplex),
    .strobe(strobe), .status(status),
    .driverEn(driverEn), .jabberFlag(jabberFlag),
    .linkPulseReq(linkPulseReq), .colStatusFlag(colStatusFlag),
    .loopbackEn(loopbackEn)
  );
endmodule

// File: rtl/txjChecker.sv
module txjChecker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic txData,
  input logic collisionIn,
  input logic fullDuplex,
  input logic sqeTestEn,
  input logic driverEn,
  input logic linkPulseReq,
  input logic jabberFlag,
  input logic colStatusFlag,
  input logic loopbackEn
);
  // R2: qualified edge from idle starts driving
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!driverEn && !jabberFlag && txEnable && (txData != $past(txData))) |=> driverEn);

  // R2: enable low keeps the driver off from idle
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!driverEn && !jabberFlag && !txEnable) |=> !driverEn);

  // R4: jabber cuts drive and loopback, raises status
  p_jab_cut_r4: assert property (@(posedge clk) disable iff (!rstN)
    jabberFlag |-> (!driverEn && !loopbackEn && colStatusFlag));

  // R5: a qualified edge inside jabber cannot end it
  p_jab_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (jabberFlag && txEnable && (txData != $past(txData))) |=> jabberFlag);

  // R6: beats only on a quiet line
  p_beat_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    linkPulseReq |-> (!driverEn && !jabberFlag));

  // R7: normal frame end with test enabled opens the window
  p_sqe_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(driverEn) && !jabberFlag && $past(sqeTestEn)) |-> colStatusFlag);

  // R8: half-duplex collision is announced
  p_col_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (collisionIn && !fullDuplex) |-> colStatusFlag);

  // R9: loopback closed on collision or full duplex
  p_loop_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex || collisionIn) |-> !loopbackEn);
endmodule

bind txJabberIdleCtl txjChecker chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .txData(txData),
  .collisionIn(collisionIn), .fullDuplex(fullDuplex), .sqeTestEn(sqeTestEn),
  .driverEn(driverEn), .linkPulseReq(linkPulseReq), .jabberFlag(jabberFlag),
  .colStatusFlag(colStatusFlag), .loopbackEn(loopbackEn)
);

// File: tb/txJabberIdleCtl_test.sv
module txJabberIdleCtl_test;
  localparam int T_HOLD = 3;
  localparam int T_JAB  = 40;
  localparam int T_REC  = 30;
  localparam int T_BP   = 50;
  localparam int T_BW   = 2;
  localparam int T_SQE  = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, txEnable = 1'b0, txData = 1'b1;
  logic collisionIn = 1'b0, fullDuplex = 1'b0, sqeTestEn = 1'b0;
  logic driverEn, linkPulseReq, jabberFlag, colStatusFlag, loopbackEn;

  int checks = 0;
  int fails = 0;

  txJabberIdleCtl #(
    .HOLD_CYCLES(T_HOLD), .JABBER_CYCLES(T_JAB), .RECOVER_CYCLES(T_REC),
    .BEAT_PERIOD(T_BP), .BEAT_WIDTH(T_BW), .SQE_CYCLES(T_SQE)
  ) uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txData(txData),
    .collisionIn(collisionIn), .fullDuplex(fullDuplex), .sqeTestEn(sqeTestEn),
    .driverEn(driverEn), .linkPulseReq(linkPulseReq), .jabberFlag(jabberFlag),
    .colStatusFlag(colStatusFlag), .loopbackEn(loopbackEn)
  );

  // reference model state: 0 idle, 1 sending, 2 jabber
  int   mSt, mSince, mRun, mQuiet, mBeat, mSqe;
  logic mPrev, mAct, mLoad;

  always @(posedge clk) mPrev <= txData;

  always @(posedge clk or negedge rstN) begin : refModel
    if (!rstN) begin
      mSt = 0; mSince = 0; mRun = 0; mQuiet = 0; mBeat = 0; mSqe = 0;
    end else begin
      mAct  = txEnable && (txData != mPrev);
      mLoad = 1'b0;
      if (mSt == 0) mBeat = (mBeat == T_BP - 1) ? 0 : mBeat + 1;
      else          mBeat = 0;
      case (mSt)
        0: if (mAct) begin mSt = 1; mSince = 0; mRun = 0; end
        1: begin
          if (mRun == T_JAB - 1) begin
            mSt = 2; mQuiet = 0;
          end else begin
            mRun++;
            if (mAct) mSince = 0;
            else if (!txEnable || mSince == T_HOLD - 1) begin
              mSt = 0; mLoad = sqeTestEn;
            end else mSince++;
          end
        end
        default: begin
          if (mAct) mQuiet = 0;
          else if (mQuiet == T_REC - 1) mSt = 0;
          else mQuiet++;
        end
      endcase
      if (mLoad) mSqe = T_SQE;
      else if (mSqe > 0) mSqe--;
    end
  end

  function automatic logic expBeat();
    return (mSt == 0) && (mBeat >= T_BP - T_BW);
  endfunction

  function automatic logic expCol();
    return (mSt == 2) || (mSqe > 0) || (collisionIn && !fullDuplex);
  endfunction

  function automatic logic expLoop();
    return (mSt == 1) && !fullDuplex && !collisionIn;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R3 driverEn model", driverEn, mSt == 1);
    check("R4 jabberFlag model", jabberFlag, mSt == 2);
    check("R6 linkPulseReq model", linkPulseReq, expBeat());
    check("R8 colStatusFlag model", colStatusFlag, expCol());
    check("R9 loopbackEn model", loopbackEn, expLoop());
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin : stimulus
    int kind, len;
    void'($urandom(32'd7321));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 driverEn in reset", driverEn, 1'b0);
    check("R1 jabberFlag in reset", jabberFlag, 1'b0);
    check("R1 linkPulseReq in reset", linkPulseReq, 1'b0);
    check("R1 colStatusFlag in reset", colStatusFlag, 1'b0);
    check("R1 loopbackEn in reset", loopbackEn, 1'b0);
    rstN = 1'b1;
    tick();

    // R2: edges with enable low are ignored
    txEnable = 1'b0;
    for (int i = 0; i < 5; i++) begin txData = ~txData; tick(); end
    check("R2 no drive with enable low", driverEn, 1'b0);
    txEnable = 1'b1;
    tick();
    check("R2 enable high without edge", driverEn, 1'b0);

    // R3 and R7: short frame, hold release, test window
    sqeTestEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      txData = ~txData;
      tick();
      check("R2 R3 driving during frame", driverEn, 1'b1);
    end
    repeat (T_HOLD - 1) tick();
    check("R3 still held at last hold cycle", driverEn, 1'b1);
    tick();
    check("R3 released after hold", driverEn, 1'b0);
    check("R7 window opens", colStatusFlag, 1'b1);
    repeat (T_SQE - 1) tick();
    check("R7 window last cycle", colStatusFlag, 1'b1);
    tick();
    check("R7 window closed", colStatusFlag, 1'b0);

    // R3: enable low ends driving at once
    sqeTestEn = 1'b0;
    txData = ~txData;
    tick();
    check("R3 drive before enable drop", driverEn, 1'b1);
    txEnable = 1'b0;
    tick();
    check("R3 enable low releases", driverEn, 1'b0);
    txEnable = 1'b1;
    repeat (4) tick();

    // R4: continuous stream enters jabber
    for (int i = 0; i < T_JAB; i++) begin txData = ~txData; tick(); end
    check("R4 last cycle before jabber", jabberFlag, 1'b0);
    check("R4 driver on before jabber", driverEn, 1'b1);
    txData = ~txData;
    tick();
    check("R4 jabber entered", jabberFlag, 1'b1);
    check("R4 driver cut", driverEn, 1'b0);
    check("R4 status raised", colStatusFlag, 1'b1);
    check("R4 loopback cut", loopbackEn, 1'b0);

    // R5: toggling keeps jabber, quiet clears it
    for (int i = 0; i < 10; i++) begin txData = ~txData; tick(); end
    check("R5 jabber held while toggling", jabberFlag, 1'b1);
    repeat (T_REC - 1) tick();
    check("R5 jabber at last quiet cycle", jabberFlag, 1'b1);
    tick();
    check("R5 jabber cleared", jabberFlag, 1'b0);

    // R6: beat phase after entering idle
    repeat (T_BP - T_BW - 1) tick();
    check("R6 no beat before slot", linkPulseReq, 1'b0);
    tick();
    check("R6 beat slot first", linkPulseReq, 1'b1);
    tick();
    check("R6 beat slot last", linkPulseReq, 1'b1);
    tick();
    check("R6 beat ends at wrap", linkPulseReq, 1'b0);

    // R8 and R9: full duplex suppresses collision, keeps test window
    fullDuplex = 1'b1;
    collisionIn = 1'b1;
    sqeTestEn = 1'b1;
    tick();
    check("R8 collision ignored in full duplex", colStatusFlag, 1'b0);
    txData = ~txData;
    tick();
    check("R9 loopback off in full duplex", loopbackEn, 1'b0);
    repeat (T_HOLD) tick();
    check("R8 test window in full duplex", colStatusFlag, 1'b1);
    fullDuplex = 1'b0;
    collisionIn = 1'b0;
    sqeTestEn = 1'b0;
    repeat (T_SQE + 2) tick();

    // random phases against the reference model
    for (int ph = 0; ph < 300; ph++) begin
      kind = $urandom_range(0, 3);
      len  = $urandom_range(1, 60);
      if ($urandom_range(0, 3) == 0) fullDuplex = ~fullDuplex;
      sqeTestEn = $urandom_range(0, 1);
      for (int c = 0; c < len; c++) begin
        collisionIn = ($urandom_range(0, 7) == 0);
        case (kind)
          0: txEnable = 1'b1;
          1: begin
            txEnable = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 4) != 0) txData = ~txData;
          end
          2: begin txEnable = 1'b1; txData = ~txData; end
          default: begin txEnable = 1'b0; txData = 1'($urandom_range(0, 1)); end
        endcase
        tick();
      end
    end

    finishRun();
  end
endmodule